// File: doc/BRIEF.md
# Reset Supervisor With Programmable Delay

This block generates a system reset from two sources: a synchronous flag from an external supply comparator that is high while the supply sits under its trip level, and a manual push-button input. While either source is active the reset output is held high. Once both have cleared, the output stays high for a programmable hold time and only then drops low. Any new event during that hold time starts it again from zero.

The push-button input comes straight from a mechanical contact. It passes through a synchronizer and a stability filter, so bounces and short glitches never reach the reset logic. A two-bit configuration code from an external nonvolatile store selects the hold time. Every duration is given in milliseconds and scaled to clock cycles by a clock-rate parameter.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `reset_o` is high and the hold timer is cleared.
- R2: A high `undervolt_i` sampled at a clock edge makes `reset_o` high after that same edge.
- R3: When `undervolt_i` is first sampled low at edge E, with no manual press in effect, `reset_o` falls at edge E+N-1, where N is the hold time in cycles. It is therefore low after exactly N cycles of clear inputs.
- R4: `dly_code_i` selects N = CLK_KHZ times 50, 100, 200 or 300 for the codes 0, 1, 2 and 3. The code must be held stable while the hold timer runs.
- R5: A debounced manual press forces `reset_o` high. After the debounced release, `reset_o` stays high for the same N cycles before it falls.
- R6: The button level goes through SYNC_STAGES flip-flops. The debounced level takes on a new value only after the synchronized value has differed from it on DEB = DEB_MS*CLK_KHZ consecutive edges, which makes it exactly SYNC_STAGES+DEB cycles behind a clean pin change. A pulse or bounce shorter than DEB cycles leaves `reset_o` unchanged.
- R7: A new under-threshold sample or manual press during the hold time drives `reset_o` high and restarts the timer from zero.
- R8: `reset_o` falls only after both sources have cleared. Clearing just one of them starts no hold time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on clear |
| undervolt_i | input | 1 | Synchronous comparator flag, high while the supply is under the trip level |
| mr_btn_i | input | 1 | Raw manual reset button, active high |
| dly_code_i | input | 2 | Hold time select (0: 50 ms, 1: 100 ms, 2: 200 ms, 3: 300 ms) |
| reset_o | output | 1 | Reset output, active high |

## Verification
The assertions check on every cycle that either source drives the output high on the next edge. They also check that the output never falls while a source is active and that each release comes exactly N cycles after the sources cleared, with N taken from the code. Only the bench's scenarios show the debounce behaviour: a pulse one cycle shorter than the filter window is rejected, a pulse of exactly the window length is accepted, and a bouncing contact is filtered. The scenarios also cover the timer restart in the middle of a hold time and the overlapping-source orderings that R8 describes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      HOLD_SHORT  = 2'd0,
      HOLD_MEDIUM = 2'd1,
      HOLD_LONG   = 2'd2,
      HOLD_XLONG  = 2'd3
   } hold_code_e;

   localparam int unsigned MAX_HOLD_MS = 300;

   function automatic int unsigned hold_ms(input hold_code_e code);
      case (code)
         HOLD_SHORT:  return 50;
         HOLD_MEDIUM: return 100;
         HOLD_LONG:   return 200;
         default:     return MAX_HOLD_MS;
      endcase
   endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] stage_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= 1'b0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rsv_debounce.sv
module rsv_debounce #(
   parameter int unsigned STABLE_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o
);
   generate
      if (STABLE_CYC == 0) begin : g_bypass
         assign level_o = din;
      end else begin : g_filter
         localparam int DW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
         localparam logic [DW-1:0] LAST = DW'(STABLE_CYC - 1);
         logic [DW-1:0] run_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b0;
            end else if (din == lvl_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               run_q <= '0;
               lvl_q <= din;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign level_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/rsv_delay_sel.sv
module rsv_delay_sel #(
   parameter int unsigned CLK_KHZ = 200000,
   parameter int          TW      = 26
) (
   input  logic [1:0]    code_i,
   output logic [TW-1:0] limit_o
);
   import rsv_pkg::*;

   always_comb begin
      limit_o = TW'(hold_ms(hold_code_e'(code_i)) * CLK_KHZ);
   end
endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer #(
   parameter int TW = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   input  logic [TW-1:0] limit_i,
   output logic          reset_o
);
   logic [TW-1:0] elapsed_q;
   logic          out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
         out_q     <= 1'b1;
      end else if (hold_i) begin
         elapsed_q <= '0;
         out_q     <= 1'b1;
      end else if (out_q) begin
         if (elapsed_q == limit_i - TW'(1)) begin
            elapsed_q <= '0;
            out_q     <= 1'b0;
         end else begin
            elapsed_q <= elapsed_q + 1'b1;
         end
      end
   end

   assign reset_o = out_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int unsigned CLK_KHZ     = 200000,
   parameter int unsigned DEB_MS      = 10,
   parameter int          SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       undervolt_i,
   input  logic       mr_btn_i,
   input  logic [1:0] dly_code_i,
   output logic       reset_o
);
   localparam int unsigned DEB_CYC = DEB_MS * CLK_KHZ;
   localparam int unsigned MAX_CYC = rsv_pkg::MAX_HOLD_MS * CLK_KHZ;
   localparam int          TW      = $clog2(MAX_CYC + 1);

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("rst_supervisor: CLK_KHZ must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rst_supervisor: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          mr_sync;
   logic          mr_level;
   logic [TW-1:0] limit;

   rsv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (mr_btn_i),
      .dout (mr_sync)
   );

   rsv_debounce #(.STABLE_CYC(DEB_CYC)) u_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (mr_sync),
      .level_o(mr_level)
   );

   rsv_delay_sel #(.CLK_KHZ(CLK_KHZ), .TW(TW)) u_sel (
      .code_i (dly_code_i),
      .limit_o(limit)
   );

   rsv_hold_timer #(.TW(TW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (undervolt_i | mr_level),
      .limit_i(limit),
      .reset_o(reset_o)
   );
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
   parameter int unsigned CLK_KHZ = 200000,
   parameter int          TW      = 26
) (
   input logic       clk,
   input logic       rst_n,
   input logic       undervolt_i,
   input logic       mr_level,
   input logic [1:0] dly_code_i,
   input logic       reset_o
);
   logic [TW-1:0] quiet_q;
   logic [TW-1:0] want;
   logic          busy;

   assign busy = undervolt_i | mr_level;

   always_comb begin
      unique case (dly_code_i)
         2'd0:    want = TW'(50  * CLK_KHZ);
         2'd1:    want = TW'(100 * CLK_KHZ);
         2'd2:    want = TW'(200 * CLK_KHZ);
         default: want = TW'(300 * CLK_KHZ);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    quiet_q <= '0;
      else if (busy || !reset_o)     quiet_q <= '0;
      else if (quiet_q != {TW{1'b1}}) quiet_q <= quiet_q + 1'b1;
   end

   p_uv_forces_r2: assert property (@(posedge clk) disable iff (!rst_n)
      undervolt_i |=> reset_o);

   p_mr_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mr_level |=> reset_o);

   p_both_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_o) |-> (!$past(undervolt_i) && !$past(mr_level)));

   p_exact_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reset_o) |-> ($past(quiet_q) == $past(want) - TW'(1)));

   p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_o && !busy && (quiet_q < want - TW'(1))) |=> reset_o);
endmodule

bind rst_supervisor rsv_checker #(.CLK_KHZ(CLK_KHZ), .TW(TW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .undervolt_i(undervolt_i),
   .mr_level   (mr_level),
   .dly_code_i (dly_code_i),
   .reset_o    (reset_o)
);

// File: tb/test_rst_supervisor.sv
`timescale 1ns/1ps
module test_rst_supervisor;
   localparam int KHZ  = 4;
   localparam int DBMS = 10;
   localparam int SYNC = 2;
   localparam int DEB  = DBMS * KHZ;
   localparam int LAT  = SYNC + DEB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uv = 1'b1;
   logic       btn = 1'b0;
   logic [1:0] code = 2'd0;
   logic       reset_o;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;
   int    exp_q[$];
   string tag_q[$];

   rst_supervisor #(.CLK_KHZ(KHZ), .DEB_MS(DBMS), .SYNC_STAGES(SYNC)) i_rst_supervisor (
      .clk(clk), .rst_n(rst_n), .undervolt_i(uv), .mr_btn_i(btn),
      .dly_code_i(code), .reset_o(reset_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int hold_n(input logic [1:0] c);
      case (c)
         2'd0:    return 50 * KHZ;
         2'd1:    return 100 * KHZ;
         2'd2:    return 200 * KHZ;
         default: return 300 * KHZ;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input int at, input string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) step(1);
      step(2);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // monitor: every falling edge of reset_o must match the next expected release
   logic prev = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev && !reset_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 R6 unexpected release", cyc, -1);
            end else begin
               automatic int    e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(cyc == e, t, cyc, e);
            end
         end
         prev = reset_o;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      int g;
      bit seen;
      step(3);
      check(reset_o == 1'b1, "R1 reset state", reset_o, 1);
      rst_n = 1'b1;
      step(1);
      check(reset_o == 1'b1, "R1 first cycle after reset", reset_o, 1);
      step(4);
      check(reset_o == 1'b1, "R2 held by undervolt", reset_o, 1);

      // R3 R4: every code
      for (int c = 0; c < 4; c++) begin
         code = 2'(c);
         uv = 1'b1;
         step(3);
         check(reset_o == 1'b1, "R2 undervolt high", reset_o, 1);
         uv = 1'b0;
         push(cyc + hold_n(2'(c)), $sformatf("R3 R4 release code %0d", c));
         drain();
      end

      // R2: single-cycle dip
      code = 2'd0;
      uv = 1'b1;
      step(1);
      check(reset_o == 1'b1, "R2 one-cycle undervolt", reset_o, 1);
      uv = 1'b0;
      push(cyc + hold_n(2'd0), "R2 R3 release after dip");
      drain();

      // R7: restart mid-hold
      uv = 1'b1;
      step(2);
      uv = 1'b0;
      step(150);
      check(reset_o == 1'b1, "R7 still holding", reset_o, 1);
      uv = 1'b1;
      step(1);
      uv = 1'b0;
      push(cyc + hold_n(2'd0), "R7 restarted hold");
      drain();

      // R5 with R6 latency
      btn = 1'b1;
      step(LAT);
      check(reset_o == 1'b0, "R6 not yet accepted", reset_o, 0);
      step(1);
      check(reset_o == 1'b1, "R5 manual press", reset_o, 1);
      step(50);
      btn = 1'b0;
      push(cyc + LAT + hold_n(2'd0), "R5 release after button");
      drain();

      // R6: pulse one cycle shorter than the window is rejected
      btn = 1'b1;
      step(DEB - 1);
      btn = 1'b0;
      seen = 0;
      for (int k = 0; k < DEB + 20; k++) begin
         step(1);
         if (reset_o) seen = 1;
      end
      check(!seen, "R6 short pulse ignored", seen, 0);

      // R6: bounce then steady press
      seen = 0;
      for (int k = 0; k < 6; k++) begin
         btn = ~btn;
         step(7);
         if (reset_o) seen = 1;
      end
      check(!seen, "R6 bounce ignored", seen, 0);
      btn = 1'b1;
      step(LAT + 1);
      check(reset_o == 1'b1, "R6 steady press accepted", reset_o, 1);
      btn = 1'b0;
      push(cyc + LAT + hold_n(2'd0), "R5 R6 release after bounce");
      drain();

      // R6: pulse of exactly the window length is accepted
      g = cyc;
      btn = 1'b1;
      step(DEB);
      btn = 1'b0;
      step(SYNC + 1);
      check(reset_o == 1'b1, "R6 window-length pulse accepted", reset_o, 1);
      push(g + LAT + DEB + hold_n(2'd0), "R6 release after minimal pulse");
      drain();

      // R8: undervolt clears while button held
      code = 2'd1;
      uv = 1'b1;
      btn = 1'b1;
      step(LAT + 5);
      uv = 1'b0;
      step(hold_n(2'd1) + 50);
      check(reset_o == 1'b1, "R8 button still held", reset_o, 1);
      btn = 1'b0;
      push(cyc + LAT + hold_n(2'd1), "R8 release after button");
      drain();

      // R8: button clears while undervolt held
      btn = 1'b1;
      step(LAT + 5);
      uv = 1'b1;
      btn = 1'b0;
      step(LAT + hold_n(2'd1) + 20);
      check(reset_o == 1'b1, "R8 undervolt still high", reset_o, 1);
      uv = 1'b0;
      push(cyc + hold_n(2'd1), "R8 release after undervolt");
      drain();

      check(exp_q.size() == 0, "R3 all releases seen", exp_q.size(), 0);
      summary();
   end
endmodule